// File: doc/BRIEF.md
# UART Bit-Rate Timing Generator

This block derives the two timing strobes a UART transmitter and receiver need from a single reference clock. The reference clock optionally passes through a fixed divide-by-8 prescaler. A programmable generator divisor then turns it into a one-cycle sample enable. A second programmable divisor groups a number of those sample enables into one bit period and marks the end of each period with a one-cycle baud tick.

Divisors and the prescaler choice are captured only while the channel enable is low. A small controller has three states, and it drives both counters:

- OFF: disabled. Inputs are captured every cycle and the counters are held at zero.
- RUN: counting.
- STALL: enabled, but with a generator divisor of zero, so no strobes are produced.

The transitions are:

- OFF→RUN: on the first enabled cycle, with a nonzero generator divisor.
- OFF→STALL: on the first enabled cycle, with a zero generator divisor.
- RUN→OFF and STALL→OFF: whenever the enable drops.

Top module: `baud_rate_gen`

## Requirements
- R1: While reset (rst_n low, active low) is asserted, and in the cycle after it is released, samp_en and baud_tick are 0.
- R2: While chan_en is 0, samp_en and baud_tick are 0 one cycle after chan_en is sampled low.
- R3: With presc_sel=1 and generator divisor G≥1, samp_en pulses once every 8·G reference cycles.
- R4: With presc_sel=0 and G≥2, samp_en pulses once every G reference cycles.
- R5: A generator divisor of 0 captured at enable produces no samp_en and no baud_tick while enabled.
- R6: G=1 bypasses the generator divider. With presc_sel=1 the period is 8 cycles. With presc_sel=0 the period is limited to 2 cycles, so that the rate never exceeds half the reference clock.
- R7: samp_en is never high in two consecutive cycles.
- R8: baud_tick pulses on every (B+1)-th samp_en, where B is the bit divisor, and only in cycles where samp_en is also high.
- R9: Counting restarts from zero at each enable. The first edge with chan_en high moves OFF to RUN. If edge 1 is that first edge, samp_en is high after edge 1+m·T for m≥1, where T is the sample period, and baud_tick is high after edge 1+m·T·(B+1).
- R10: Changes on gen_div, bit_div or presc_sel while chan_en is 1 have no effect until the channel is disabled and re-enabled.
- R11: samp_en and baud_tick are single-cycle pulses in the reference clock domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; divisors captured while low |
| presc_sel | input | 1 | 1 = insert divide-by-8 prescaler |
| gen_div | input | 32 | Generator divisor (0 = off, 1 = bypass) |
| bit_div | input | 32 | Bit divisor; bit period is bit_div+1 samples |
| samp_en | output | 1 | One-cycle sample-rate enable |
| baud_tick | output | 1 | One-cycle bit-period tick |

## Verification
The assertions check, on every cycle, the properties that need no knowledge of the programmed period:

- the half-rate ceiling on samp_en;
- that baud_tick only occurs together with samp_en;
- that both outputs are quiet while disabled;
- that no counter runs past its terminal value;
- that a zero generator divisor stays silent.

The exact periods, the restart alignment after enable and the immunity to input changes while running depend on the programmed values. Only the bench's sweep over prescaler choice, generator divisors 0 to 4 and bit divisors 0 to 3 can show these. It compares every cycle against periods computed arithmetically.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int unsigned DIV_W      = 32;
    localparam int unsigned PRESC_DIV  = 8;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_STALL = 2'd2
    } brg_state_e;
endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
    parameter int unsigned DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel,
    output logic strb
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (!run)   cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    always_comb strb = run && (sel ? (cnt == LAST) : 1'b1);

    // Prescaled strobe is at most one cycle wide
    assert_presc_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sel && strb) |=> !strb);
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] last,
    output logic         strb
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (clr)       cnt <= '0;
        else if (step) begin
            if (cnt == last) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end

    always_comb strb = step && !clr && (cnt == last);

    // Counter never passes its terminal value while running
    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (cnt <= last));
endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
    import baud_pkg::*;
#(
    parameter int unsigned W     = DIV_W,
    parameter int unsigned PDIV  = PRESC_DIV
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         chan_en,
    input  logic         presc_sel,
    input  logic [W-1:0] gen_div,
    input  logic [W-1:0] bit_div,
    output logic         samp_en,
    output logic         baud_tick
);
    brg_state_e   state, state_nx;
    logic [W-1:0] gdiv_q, bdiv_q, gen_last;
    logic         sel_q, running, presc_strb, gen_strb, bit_strb;

    // ---------------- state register ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   if (chan_en) state_nx = (gen_div == '0) ? ST_STALL : ST_RUN;
            ST_RUN:   if (!chan_en) state_nx = ST_OFF;
            ST_STALL: if (!chan_en) state_nx = ST_OFF;
            default:  state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // Divisor capture while disabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gdiv_q <= '0;
            bdiv_q <= '0;
            sel_q  <= 1'b0;
        end else if (state == ST_OFF) begin
            gdiv_q <= gen_div;
            bdiv_q <= bit_div;
            sel_q  <= presc_sel;
        end
    end

    always_comb begin
        running = (state == ST_RUN);
        // Without prescaler, divisor 1 is clamped to 2 (half-rate ceiling)
        if (!sel_q && gdiv_q == W'(1)) gen_last = W'(1);
        else                            gen_last = gdiv_q - W'(1);
    end

    baud_prescale #(.DIV(PDIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(running), .sel(sel_q), .strb(presc_strb)
    );

    baud_divider #(.W(W)) u_gen (
        .clk(clk), .rst_n(rst_n), .clr(!running), .step(presc_strb),
        .last(gen_last), .strb(gen_strb)
    );

    baud_divider #(.W(W)) u_bit (
        .clk(clk), .rst_n(rst_n), .clr(!running), .step(gen_strb),
        .last(bdiv_q), .strb(bit_strb)
    );

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_en   <= 1'b0;
            baud_tick <= 1'b0;
        end else begin
            samp_en   <= chan_en && running && gen_strb;
            baud_tick <= chan_en && running && bit_strb;
        end
    end

    assert_max_rate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        samp_en |=> !samp_en);
    assert_tick_with_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> samp_en);
    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (!samp_en && !baud_tick));
    assert_zero_div_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL) |=> !samp_en);
    assert_single_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick);
endmodule

// File: tb/baud_rate_gen_tb.sv
module baud_rate_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b0;
    logic        presc_sel = 1'b0;
    logic [31:0] gen_div = '0;
    logic [31:0] bit_div = '0;
    logic        samp_en, baud_tick;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    baud_rate_gen u_dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .presc_sel(presc_sel),
        .gen_div(gen_div), .bit_div(bit_div), .samp_en(samp_en), .baud_tick(baud_tick)
    );

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic run_cfg(input logic sel, input int g, input int b, input bit scramble);
        int t, per, ncyc;
        string stag;
        @(negedge clk);
        chan_en = 1'b0; presc_sel = sel; gen_div = 32'(g); bit_div = 32'(b);
        repeat (2) begin
            @(negedge clk);
            chk("R2", samp_en, 1'b0, "samp_en disabled");
            chk("R2", baud_tick, 1'b0, "baud_tick disabled");
        end
        if (sel) t = 8 * g; else t = (g < 2) ? 2 : g;
        per  = t * (b + 1);
        ncyc = (g == 0) ? 60 : 2 * per + 3;
        if (g == 0) stag = "R5"; else if (g == 1) stag = "R6"; else if (sel) stag = "R3"; else stag = "R4";
        chan_en = 1'b1;
        for (int k = 1; k <= ncyc; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (scramble && k == 2) begin
                // R10: inputs change while enabled must be ignored
                presc_sel = ~sel; gen_div = 32'(g + 3); bit_div = 32'(b + 2);
            end
            begin
                int j;
                logic es, eb;
                j  = k - 1;
                es = (g != 0) && (j > 0) && (j % t == 0);
                eb = (g != 0) && (j > 0) && (j % per == 0);
                chk(scramble ? "R10" : (j == t ? "R9" : stag), samp_en, es, "samp_en");
                chk(scramble ? "R10" : "R8", baud_tick, eb, "baud_tick");
            end
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", samp_en, 1'b0, "samp_en in reset");
        chk("R1", baud_tick, 1'b0, "baud_tick in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", samp_en, 1'b0, "samp_en after reset");
        chk("R1", baud_tick, 1'b0, "baud_tick after reset");

        // Sweep: R3, R4, R5, R6, R8, R9, R11 (single-cycle pulses via per-cycle compare)
        for (int s = 0; s < 2; s++)
            for (int g = 0; g <= 4; g++)
                for (int b = 0; b <= 3; b++)
                    run_cfg(logic'(s), g, b, 1'b0);

        // R10: reprogramming attempts while running
        run_cfg(1'b0, 2, 1, 1'b1);
        run_cfg(1'b1, 1, 2, 1'b1);
        run_cfg(1'b0, 3, 0, 1'b1);

        // R1: reset mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", samp_en, 1'b0, "samp_en mid-run reset");
        chk("R1", baud_tick, 1'b0, "baud_tick mid-run reset");
        rst_n = 1'b1;
        chan_en = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule